// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage

This block is one pipelined stage of a decimation-in-frequency FFT built from single-path delay-feedback butterflies. It takes one complex sample per cycle and returns one complex sample per cycle. Inside, a butterfly with a feedback delay of x samples is followed by a multiply by 1 or −j, and then by a second butterfly with a delay of x/2 samples. The −j multiply is done only by swapping the real and imaginary parts and negating one of them, so the stage needs no real multiplier. Here x = 2^X_LOG. Across each aligned block of 2x samples, the stage computes the first two radix-2 decimation passes of a 2x-point transform. Results leave in bit-reversed order.

The stage is steered by a frame counter that travels with the data. `cnt_in` gives the position of the incoming sample. `cnt_out` gives the position of the outgoing sample, so the next stage can use it unchanged. When the transform size is reduced, a stage that is not needed is switched to bypass. In bypass, samples pass through one register and the delay lines keep their contents. Deasserting the enable freezes the whole stage. Each butterfly widens the word by one bit, so the output is two bits wider than the input and no precision is lost.

Top module: `r22_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout_re`, `dout_im` and `cnt_out` become zero.
- R2: Every cycle with `en`=1 and `bypass`=0 accepts one sample and presents one result after the edge. The result belongs to the stream position 3x/2 samples earlier, and `cnt_out` equals `cnt_in` − 3x/2 modulo 2^CW.
- R3: A frame is a block of 2x accepted samples that starts where `cnt_in` mod 2x = 0. For m < x/2, let a, b, c, d be frame samples m, m+x/2, m+x and m+3x/2. Output position m carries a+b+c+d, and output position x/2+m carries (a+c)−(b+d).
- R4: With the same a, b, c, d, output position x+m carries (a−c)−j(b−d), and output position 3x/2+m carries (a−c)+j(b−d). This is the bit-reversed 4-point transform order.
- R5: The outputs are W+2 bits, two's complement. Results are exact for all inputs, including the full-scale values −2^(W−1) and 2^(W−1)−1.
- R6: A cycle with `en`=0 changes neither the outputs nor `cnt_out`, and consumes no sample. The result stream after the stall is the same as if the stall had not happened.
- R7: A cycle with `en`=1 and `bypass`=1 makes `dout` equal to the sign-extended `din`, and `cnt_out` equal to `cnt_in`, after the edge.
- R8: Bypass cycles leave both delay lines unchanged. Once bypass ends, the result stream continues as if the bypass cycles had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Stage enable; low holds all state |
| bypass | input | 1 | Pass input straight to the output register and freeze the delay lines |
| cnt_in | input | CW | Frame position of the incoming sample |
| din_re | input | W | Input real part, signed |
| din_im | input | W | Input imaginary part, signed |
| dout_re | output | W+2 | Output real part, signed |
| dout_im | output | W+2 | Output imaginary part, signed |
| cnt_out | output | CW | Frame position of the outgoing sample |

## Verification
The stage is driven with single impulses at different frame positions. An impulse lights exactly one of the four butterfly input lanes, so a wrong pairing distance or a wrong quadrant shows up directly. Ramps with separate real and imaginary slopes tell a −j rotation apart from a +j rotation or a plain swap. Full-scale frames test the word growth. Stalls and bypass runs are inserted in the middle of frames: any state disturbed by the interruption corrupts the outputs that follow it.

// File: rtl/r22_pkg.sv
// Shared types for the radix-2² stage.
// Assumes: nothing beyond the importing module's clocking.
package r22_pkg;
    // Butterfly phase: fill the delay line, or combine stored and incoming data
    typedef enum logic {
        PH_FILL    = 1'b0,
        PH_COMBINE = 1'b1
    } bf_phase_e;

    // True in the last quarter of a period, given its two top counter bits
    function automatic logic in_last_quarter(input logic hi, input logic lo);
        return hi & lo;
    endfunction
endpackage

// File: rtl/r22_delay_line.sv
// Fixed-length shift register that shifts only when 'shift' is high.
// Assumes: DEPTH >= 1; the contents reset to zero.
module r22_delay_line #(
    parameter int DW    = 9,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic signed [DW-1:0] d,
    output logic signed [DW-1:0] q
);
    localparam int TOTAL = DW * DEPTH;

    logic [TOTAL-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_single
            // Single tap: one register
            always_ff @(posedge clk) begin
                if (!rst_n)     sr <= '0;
                else if (shift) sr <= d;
            end
        end else begin : g_chain
            // Multi-tap: new sample enters at the low end, oldest leaves at the top
            always_ff @(posedge clk) begin
                if (!rst_n)     sr <= '0;
                else if (shift) sr <= {sr[TOTAL-DW-1:0], d};
            end
        end
    endgenerate

    assign q = sr[TOTAL-1 -: DW];

    // R6 R8
    frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(q));
endmodule

// File: rtl/r22_bfly.sv
// Single-path delay-feedback radix-2 butterfly, delay DEPTH.
// In the fill phase, the input is stored and the stored data is forwarded.
// In the combine phase, the sum goes out and the difference is fed back.
// Assumes: phase toggles every DEPTH accepted samples; output grows by one bit.
module r22_bfly
    import r22_pkg::*;
#(
    parameter int DW_IN = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  bf_phase_e                phase,
    input  logic signed [DW_IN-1:0]  in_re,
    input  logic signed [DW_IN-1:0]  in_im,
    output logic signed [DW_IN:0]    out_re,
    output logic signed [DW_IN:0]    out_im
);
    localparam int DW_OUT = DW_IN + 1;

    logic signed [DW_OUT-1:0] ext_re, ext_im;
    logic signed [DW_OUT-1:0] fb_d_re, fb_d_im;
    logic signed [DW_OUT-1:0] fb_q_re, fb_q_im;

    assign ext_re = DW_OUT'(in_re);
    assign ext_im = DW_OUT'(in_im);

    // Butterfly arithmetic and feedback selection
    always_comb begin
        if (phase == PH_COMBINE) begin
            out_re  = fb_q_re + ext_re;
            out_im  = fb_q_im + ext_im;
            fb_d_re = fb_q_re - ext_re;
            fb_d_im = fb_q_im - ext_im;
        end else begin
            out_re  = fb_q_re;
            out_im  = fb_q_im;
            fb_d_re = ext_re;
            fb_d_im = ext_im;
        end
    end

    r22_delay_line #(.DW(DW_OUT), .DEPTH(DEPTH)) fb_re_i (
        .clk(clk), .rst_n(rst_n), .shift(shift), .d(fb_d_re), .q(fb_q_re));
    r22_delay_line #(.DW(DW_OUT), .DEPTH(DEPTH)) fb_im_i (
        .clk(clk), .rst_n(rst_n), .shift(shift), .d(fb_d_im), .q(fb_q_im));

    // R3
    combine_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMBINE) |->
            ((DW_OUT+1)'(out_re) + (DW_OUT+1)'(fb_d_re)) == ((DW_OUT+1)'(fb_q_re) <<< 1));
endmodule

// File: rtl/r22_negj.sv
// Trivial multiplier: passes data unchanged, or multiplies it by -j
// by swapping the components and negating the new imaginary part.
// Assumes: the operand is never the most negative value when rotated.
module r22_negj #(
    parameter int DW = 9
) (
    input  logic                 rotate,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    // (re + j im) * -j = im - j re
    always_comb begin
        if (rotate) begin
            out_re = in_im;
            out_im = -in_re;
        end else begin
            out_re = in_re;
            out_im = in_im;
        end
    end
endmodule

// File: rtl/r22_stage.sv
// One radix-2² decimation-in-frequency stage: butterfly (delay x),
// then a multiply by 1 or -j, then a butterfly (delay x/2), then an output register.
// Assumes: cnt_in gives the frame position of din; CW >= X_LOG+1; X_LOG >= 1.
module r22_stage
    import r22_pkg::*;
#(
    parameter int W     = 8,
    parameter int X_LOG = 2,
    parameter int CW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 bypass,
    input  logic [CW-1:0]        cnt_in,
    input  logic signed [W-1:0]  din_re,
    input  logic signed [W-1:0]  din_im,
    output logic signed [W+1:0]  dout_re,
    output logic signed [W+1:0]  dout_im,
    output logic [CW-1:0]        cnt_out
);
    localparam int X    = 1 << X_LOG;
    localparam int HALF = X / 2;
    localparam int LAT  = X + HALF;
    localparam int W1   = W + 1;
    localparam int W2   = W + 2;

    logic                 run;
    logic [CW-1:0]        cnt_mid;
    bf_phase_e            ph_first, ph_second;
    logic                 rot;
    logic signed [W1-1:0] b1_re, b1_im, m_re, m_im;
    logic signed [W2-1:0] b2_re, b2_im;

    assign run     = en & ~bypass;
    // Counter aligned to the samples leaving the first butterfly
    assign cnt_mid   = cnt_in - CW'(X);
    assign ph_first  = bf_phase_e'(cnt_in[X_LOG]);
    assign ph_second = bf_phase_e'(cnt_mid[X_LOG-1]);
    assign rot       = in_last_quarter(cnt_mid[X_LOG], cnt_mid[X_LOG-1]);

    r22_bfly #(.DW_IN(W), .DEPTH(X)) bf_first_i (
        .clk(clk), .rst_n(rst_n), .shift(run), .phase(ph_first),
        .in_re(din_re), .in_im(din_im), .out_re(b1_re), .out_im(b1_im));

    r22_negj #(.DW(W1)) negj_i (
        .rotate(rot), .in_re(b1_re), .in_im(b1_im), .out_re(m_re), .out_im(m_im));

    r22_bfly #(.DW_IN(W1), .DEPTH(HALF)) bf_second_i (
        .clk(clk), .rst_n(rst_n), .shift(run), .phase(ph_second),
        .in_re(m_re), .in_im(m_im), .out_re(b2_re), .out_im(b2_im));

    // Output register: butterfly result, bypassed input, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_re <= '0;
            dout_im <= '0;
            cnt_out <= '0;
        end else if (en) begin
            if (bypass) begin
                dout_re <= W2'(din_re);
                dout_im <= W2'(din_im);
                cnt_out <= cnt_in;
            end else begin
                dout_re <= b2_re;
                dout_im <= b2_im;
                cnt_out <= cnt_in - CW'(LAT);
            end
        end
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout_re) && $stable(dout_im) && $stable(cnt_out)));

    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bypass) |=> (cnt_out == $past(cnt_in)) &&
                           (dout_re == $signed($past(din_re))) &&
                           (dout_im == $signed($past(din_im))));

    // R2
    count_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass) |=> (CW'(cnt_out + CW'(LAT)) == $past(cnt_in)));
endmodule

// File: tb/r22_stage_tb_top.sv
// Directed bench for r22_stage: each task drives one scenario and checks its results.
module r22_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int X_LOG = 2;
    localparam int CW    = 6;
    localparam int X     = 1 << X_LOG;
    localparam int HALF  = X / 2;
    localparam int LAT   = X + HALF;
    localparam int FRAME = 2 * X;
    localparam int MASK  = (1 << CW) - 1;

    logic                clk = 1'b0;
    logic                rst_n, en, bypass;
    logic [CW-1:0]       cnt_in;
    logic signed [W-1:0] din_re, din_im;
    logic signed [W+1:0] dout_re, dout_im;
    logic [CW-1:0]       cnt_out;

    int checks = 0;
    int errors = 0;
    int t_next = 0;
    int hist_re [0:2047];
    int hist_im [0:2047];

    r22_stage #(.W(W), .X_LOG(X_LOG), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .cnt_in(cnt_in),
        .din_re(din_re), .din_im(din_im),
        .dout_re(dout_re), .dout_im(dout_im), .cnt_out(cnt_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result at output stream position idx, from the requirement formulas
    function automatic void expect_at(input int idx, output int er, output int ei);
        int base, p, q, m, ar, ai, br, bi, cr, ci, dr, di;
        base = (idx / FRAME) * FRAME;
        p = idx % FRAME;
        q = p / HALF;
        m = p % HALF;
        ar = hist_re[base+m];        ai = hist_im[base+m];
        br = hist_re[base+m+HALF];   bi = hist_im[base+m+HALF];
        cr = hist_re[base+m+X];      ci = hist_im[base+m+X];
        dr = hist_re[base+m+LAT];    di = hist_im[base+m+LAT];
        case (q)
            0: begin er = ar+br+cr+dr;           ei = ai+bi+ci+di; end
            1: begin er = (ar+cr)-(br+dr);       ei = (ai+ci)-(bi+di); end
            2: begin er = (ar-cr)+(bi-di);       ei = (ai-ci)-(br-dr); end
            default: begin er = (ar-cr)-(bi-di); ei = (ai-ci)+(br-dr); end
        endcase
    endfunction

    // Accept one sample and check the result that comes out of the register
    task automatic push(input int re, input int im, input string tag);
        int idx, er, ei;
        string req;
        en = 1'b1; bypass = 1'b0;
        din_re = W'(re); din_im = W'(im);
        cnt_in = CW'(t_next);
        hist_re[t_next] = re; hist_im[t_next] = im;
        @(posedge clk); @(negedge clk);
        idx = t_next - LAT;
        check("R2", "cnt_out", int'(cnt_out), (t_next - LAT) & MASK);
        if (idx >= 0) begin
            expect_at(idx, er, ei);
            if (tag != "") req = tag;
            else req = ((idx % FRAME) / HALF < 2) ? "R3" : "R4";
            check(req, "dout_re", int'($signed(dout_re)), er);
            check(req, "dout_im", int'($signed(dout_im)), ei);
        end
        t_next++;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; bypass = 1'b0; cnt_in = '0; din_re = '0; din_im = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "dout_re after reset", int'(dout_re), 0);
        check("R1", "dout_im after reset", int'(dout_im), 0);
        check("R1", "cnt_out after reset", int'(cnt_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_impulses();
        for (int f = 0; f < 4; f++)
            for (int p = 0; p < FRAME; p++)
                push((p == (f*3) % FRAME) ? 1 : 0, (p == (f*5+1) % FRAME) ? 7 : 0, "");
    endtask

    task automatic t_ramps();
        for (int f = 0; f < 3; f++)
            for (int p = 0; p < FRAME; p++)
                push(p*3 - 7 + f, 11 - p*5 - f, "");
    endtask

    task automatic t_extremes();
        for (int p = 0; p < FRAME; p++) push(-128, 127, "R5");
        for (int p = 0; p < FRAME; p++) push(-128, -128, "R5");
        for (int p = 0; p < FRAME; p++) push((p < X) ? 127 : -128, (p % 2 == 0) ? -128 : 127, "R5");
        for (int p = 0; p < FRAME; p++) push(((p / HALF) % 2 == 0) ? -128 : 127, (p < X) ? -128 : 127, "R5");
    endtask

    task automatic t_stall();
        int hr, hi, hc;
        for (int p = 0; p < 3; p++) push(p + 2, -p, "");
        hr = int'($signed(dout_re)); hi = int'($signed(dout_im)); hc = int'(cnt_out);
        for (int s = 0; s < 3; s++) begin
            en = 1'b0; din_re = W'(55 + s); din_im = W'(-40); cnt_in = CW'(s + 17);
            @(posedge clk); @(negedge clk);
            check("R6", "dout_re during stall", int'($signed(dout_re)), hr);
            check("R6", "dout_im during stall", int'($signed(dout_im)), hi);
            check("R6", "cnt_out during stall", int'(cnt_out), hc);
        end
        for (int p = 0; p < 2*FRAME; p++) push(9 - p, p*2 - 5, "R6");
    endtask

    task automatic t_bypass();
        for (int p = 0; p < 5; p++) push(p*7 - 20, 3 - p, "");
        for (int s = 0; s < 6; s++) begin
            en = 1'b1; bypass = 1'b1;
            din_re = W'(s*41 - 128); din_im = W'(100 - s*37); cnt_in = CW'(s*11 + 3);
            @(posedge clk); @(negedge clk);
            check("R7", "dout_re in bypass", int'($signed(dout_re)), s*41 - 128);
            check("R7", "dout_im in bypass", int'($signed(dout_im)), 100 - s*37);
            check("R7", "cnt_out in bypass", int'(cnt_out), (s*11 + 3) & MASK);
        end
        for (int p = 0; p < 2*FRAME; p++) push(p*p % 17 - 8, 6 - p, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_impulses();
        t_ramps();
        t_extremes();
        t_stall();
        t_bypass();
        for (int p = 0; p < 2*FRAME; p++) push(0, 0, "");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule